// File: doc/BRIEF.md
# Bit-Masked Single-Port SRAM

This block is a single-port static RAM with separate write-data and read-data buses, active-low controls and a per-bit write mask. A system clock samples every control and data input. A write cycle is framed by the falling and the rising edge of the active-low write strobe. Those edges are found by comparing each new sample of the strobe with the one before it. When the cycle ends, only the bits whose mask bit is low are merged into the addressed word. The other bits of that word keep their stored value.

While the chip is selected and the write strobe is high, the read path follows the address. The output holds its last value in standby and for the whole of a write cycle. An output-enable input works independently of everything else and switches a drive flag that stands for the tri-state buffer. Data flows through plain pins with no handshake, because the array accepts a sample on every clock and has no back-pressure to signal. A synchronous reset clears the control history and the output register but leaves the array untouched. A word that has never been written reads as undefined.

Top module: `bitmask_sram`

## Requirements
- R1: While `rst` is high at a rising clock edge, `rd_data` becomes 0 and `rd_drive` becomes 0. No write cycle is in progress after reset.
- R2: A write cycle starts only when `wr_strobe_n` goes from 1 to 0 between two consecutive samples while `chip_sel_n` is sampled 0. A falling strobe with `chip_sel_n` high starts nothing. Selecting the chip while the strobe is already low also starts nothing, and the later rising strobe writes nothing.
- R3: At the end of a write cycle, bit i of the addressed word takes `wr_data[i]` when `bit_mask_n[i]` is 0. It keeps its old value when `bit_mask_n[i]` is 1.
- R4: A mask of all ones leaves the word unchanged. A mask of all zeros replaces the whole word.
- R5: The write commits on the sample where `wr_strobe_n` is first seen high again, using the address, data and mask sampled at that same point. If `chip_sel_n` is sampled high at that point, the cycle ends without writing.
- R6: Inputs presented before clock edge k are sampled at edge k. With `chip_sel_n`=0 and `wr_strobe_n`=1, `rd_data` shows the word at the sampled address after edge k+1. It follows a new address on every cycle.
- R7: The read in the cycle that ends a write returns the newly merged word.
- R8: While `chip_sel_n` is sampled high, `rd_data` keeps its value and the address and data inputs have no effect.
- R9: From the start of a write cycle until the strobe is seen high again, `rd_data` keeps the value it had before the write began.
- R10: `rd_drive` equals the inverse of `out_en_n`, with the same two-edge delay as R6. `out_en_n` does not affect the stored data or the value of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of control history and output |
| chip_sel_n | input | 1 | Active-low chip select; high means standby |
| wr_strobe_n | input | 1 | Active-low write strobe; its falling and rising edges frame a write |
| out_en_n | input | 1 | Active-low output enable for the read bus |
| addr | input | ADDR_W | Word address, log2 of WORDS bits |
| wr_data | input | WIDTH | Data to be written |
| bit_mask_n | input | WIDTH | Per-bit write enable, low means write that bit |
| rd_data | output | WIDTH | Registered read data |
| rd_drive | output | 1 | High when `rd_data` is driven; low stands for high impedance |

## Verification
The bench targets the edge cases of the write framing. These are a strobe that falls during standby and is then selected while low, a write whose chip select drops before the strobe rises, and masks of all ones, all zeros and mixed patterns. A design that detected the strobe by level instead of by edge would commit the aborted or never-started writes, and the following read would expose the corrupted word. The bench also reads in the very cycle a write ends. A design without the merge bypass would return the stale word there. Other checks cover output holding during standby and writes, so a read path that leaks the incoming data or a new address shows up as a changed `rd_data`. Switching the output enable in the middle of reads catches a drive flag that is tied to the data path.

// File: rtl/bitmask_sram_pkg.sv
package bitmask_sram_pkg;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_WRITE = 1'b1
  } wr_phase_e;

endpackage

// File: rtl/bitmask_sram_sampler.sv
module bitmask_sram_sampler
  import bitmask_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              wr_strobe_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  bit_mask_n,
  output logic              smp_sel_n,
  output logic              smp_oe_n,
  output logic              smp_we_n,
  output logic [ADDR_W-1:0] smp_addr,
  output logic [WIDTH-1:0]  smp_data,
  output logic [WIDTH-1:0]  smp_mask_n,
  output logic              in_write,
  output logic              strobe_rise,
  output logic              commit,
  output logic              read_go
);

  logic      prev_we_n;
  logic      strobe_fall;
  wr_phase_e phase_q, phase_d;

  // Input sample stage; strobe history powers up high (inactive).
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_sel_n  <= 1'b1;
      smp_oe_n   <= 1'b1;
      smp_we_n   <= 1'b1;
      prev_we_n  <= 1'b1;
      smp_addr   <= '0;
      smp_data   <= '0;
      smp_mask_n <= '1;
    end else begin
      smp_sel_n  <= chip_sel_n;
      smp_oe_n   <= out_en_n;
      smp_we_n   <= wr_strobe_n;
      prev_we_n  <= smp_we_n;
      smp_addr   <= addr;
      smp_data   <= wr_data;
      smp_mask_n <= bit_mask_n;
    end
  end

  // Edge detection by comparing successive samples.
  assign strobe_fall = prev_we_n & ~smp_we_n;
  assign strobe_rise = ~prev_we_n & smp_we_n;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (strobe_fall && !smp_sel_n) phase_d = PH_WRITE;
      PH_WRITE: if (strobe_rise)               phase_d = PH_IDLE;
      default:                                  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign in_write = (phase_q == PH_WRITE);
  assign commit   = in_write & strobe_rise & ~smp_sel_n;
  // A selected, strobe-high sample is a read; in the write phase this
  // can only be the closing sample.
  assign read_go  = ~smp_sel_n & smp_we_n;

endmodule

// File: rtl/bitmask_sram_merge.sv
module bitmask_sram_merge #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] old_word,
  input  logic [WIDTH-1:0] new_data,
  input  logic [WIDTH-1:0] mask_n,
  output logic [WIDTH-1:0] merged
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign merged[b] = mask_n[b] ? old_word[b] : new_data[b];
  end

endmodule

// File: rtl/bitmask_sram_store.sv
module bitmask_sram_store #(
  parameter int WORDS  = 64,
  parameter int WIDTH  = 16,
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_word
);

  logic [WIDTH-1:0] cells [WORDS];

  // Array is not reset: contents persist across reset.
  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_word;
  end

  assign rd_word = cells[rd_addr];

endmodule

// File: rtl/bitmask_sram_out.sv
module bitmask_sram_out #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             read_go,
  input  logic             commit,
  input  logic             smp_oe_n,
  input  logic [WIDTH-1:0] array_word,
  input  logic [WIDTH-1:0] merged_word,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_drive
);

  logic [WIDTH-1:0] next_word;

  // Bypass: closing sample of a write reads the merged word.
  assign next_word = commit ? merged_word : array_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      if (read_go) rd_data <= next_word;
      rd_drive <= ~smp_oe_n;
    end
  end

endmodule

// File: rtl/bitmask_sram.sv
module bitmask_sram
  import bitmask_sram_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int WIDTH  = 16,
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              wr_strobe_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  bit_mask_n,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_drive
);

  logic              smp_sel_n, smp_oe_n, smp_we_n;
  logic [ADDR_W-1:0] smp_addr;
  logic [WIDTH-1:0]  smp_data, smp_mask_n;
  logic              in_write, strobe_rise, commit, read_go;
  logic [WIDTH-1:0]  array_word, merged_word;

  bitmask_sram_sampler #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_smp (
    .clk         (clk),
    .rst         (rst),
    .chip_sel_n  (chip_sel_n),
    .wr_strobe_n (wr_strobe_n),
    .out_en_n    (out_en_n),
    .addr        (addr),
    .wr_data     (wr_data),
    .bit_mask_n  (bit_mask_n),
    .smp_sel_n   (smp_sel_n),
    .smp_oe_n    (smp_oe_n),
    .smp_we_n    (smp_we_n),
    .smp_addr    (smp_addr),
    .smp_data    (smp_data),
    .smp_mask_n  (smp_mask_n),
    .in_write    (in_write),
    .strobe_rise (strobe_rise),
    .commit      (commit),
    .read_go     (read_go)
  );

  bitmask_sram_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (smp_addr),
    .wr_word (merged_word),
    .rd_addr (smp_addr),
    .rd_word (array_word)
  );

  bitmask_sram_merge #(.WIDTH(WIDTH)) u_merge (
    .old_word (array_word),
    .new_data (smp_data),
    .mask_n   (smp_mask_n),
    .merged   (merged_word)
  );

  bitmask_sram_out #(.WIDTH(WIDTH)) u_out (
    .clk         (clk),
    .rst         (rst),
    .read_go     (read_go),
    .commit      (commit),
    .smp_oe_n    (smp_oe_n),
    .array_word  (array_word),
    .merged_word (merged_word),
    .rd_data     (rd_data),
    .rd_drive    (rd_drive)
  );

endmodule

// File: rtl/bitmask_sram_chk.sv
module bitmask_sram_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_sel_n,
  input logic             smp_oe_n,
  input logic             smp_we_n,
  input logic             in_write,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_drive
);

  // R8
  standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    smp_sel_n |=> $stable(rd_data));

  // R9
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_write && !smp_we_n) |=> $stable(rd_data));

  // R10
  drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    smp_oe_n |=> !rd_drive);

  // R2
  write_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_write) |-> $past(!smp_sel_n && !smp_we_n));

  // R5
  write_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_write) |-> $past(smp_we_n));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && !rd_drive && !in_write));

endmodule

bind bitmask_sram bitmask_sram_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_sel_n (smp_sel_n),
  .smp_oe_n  (smp_oe_n),
  .smp_we_n  (smp_we_n),
  .in_write  (in_write),
  .rd_data   (rd_data),
  .rd_drive  (rd_drive)
);

// File: tb/sim_bitmask_sram.sv
module sim_bitmask_sram;
  localparam int PERIOD = 10;
  localparam int WORDS  = 64;
  localparam int WIDTH  = 16;
  localparam int AW     = $clog2(WORDS);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             chip_sel_n = 1'b1;
  logic             wr_strobe_n = 1'b1;
  logic             out_en_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] bit_mask_n = '1;
  logic [WIDTH-1:0] rd_data;
  logic             rd_drive;

  bitmask_sram #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .wr_strobe_n(wr_strobe_n),
    .out_en_n(out_en_n), .addr(addr), .wr_data(wr_data),
    .bit_mask_n(bit_mask_n), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [WIDTH-1:0] model [WORDS];
  logic [WIDTH-1:0] exp_last = '0;

  // Scoreboard queues
  int               q_due  [$];
  logic [WIDTH-1:0] q_data [$];
  bit               q_drv  [$];
  string            q_tag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic compare(string tag, logic [WIDTH-1:0] got_d, bit got_v,
                         logic [WIDTH-1:0] exp_d, bit exp_v);
    n_cmp++;
    if (got_v !== exp_v || (exp_v && got_d !== exp_d)) begin
      n_bad++;
      $display("FAIL %s: got data=%h drive=%b, expected data=%h drive=%b",
               tag, got_d, got_v, exp_d, exp_v);
    end
  endtask

  // Expect value two edges after the current drive point.
  task automatic expect_out(string tag, logic [WIDTH-1:0] d);
    q_due.push_back(cyc + 2);
    q_data.push_back(d);
    q_drv.push_back(out_en_n == 1'b0);
    q_tag.push_back(tag);
  endtask

  // Monitor: pops items whose due cycle has arrived.
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      compare(q_tag[0], rd_data, rd_drive, q_data[0], q_drv[0]);
      void'(q_due.pop_front());
      void'(q_data.pop_front());
      void'(q_drv.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic do_read(logic [AW-1:0] a, string tag);
    @(negedge clk);
    chip_sel_n = 0; wr_strobe_n = 1; addr = a; wr_data = ~model[a];
    exp_last = model[a];
    expect_out(tag, exp_last);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [WIDTH-1:0] d,
                          logic [WIDTH-1:0] m, string tag);
    @(negedge clk);
    chip_sel_n = 0; wr_strobe_n = 0; addr = a; wr_data = d; bit_mask_n = m;
    expect_out("R9 hold at write start", exp_last);
    @(negedge clk);
    expect_out("R9 hold during write", exp_last);
    @(negedge clk);
    wr_strobe_n = 1;
    model[a] = (model[a] & m) | (d & ~m);
    exp_last = model[a];
    expect_out(tag, exp_last);
  endtask

  task automatic go_standby(logic [AW-1:0] a, logic we);
    @(negedge clk);
    chip_sel_n = 1; wr_strobe_n = we; addr = a; wr_data = 16'hBEEF;
    bit_mask_n = '0;
    expect_out("R8 standby hold", exp_last);
  endtask

  initial begin
    #(PERIOD * 50000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare("R1 reset output", rd_data, rd_drive, '0, 1'b0);
    out_en_n = 0;

    // R4 all-zero mask writes the full word; R7 read at write end
    do_write(6'd3, 16'hA5C3, 16'h0000, "R4/R7 full write addr3");
    do_write(6'd10, 16'h1234, 16'h0000, "R4/R7 full write addr10");
    // R6 read follows address each cycle
    do_read(6'd3, "R6 read addr3");
    do_read(6'd10, "R6 read addr10");
    do_read(6'd3, "R6 read addr3 again");
    // R3 mixed mask: low byte written only
    do_write(6'd3, 16'hFFFF, 16'hFF00, "R3 low byte write");
    do_read(6'd3, "R3 readback");
    // R4 all-ones mask writes nothing
    do_write(6'd10, 16'h0000, 16'hFFFF, "R4 all-ones mask");
    do_read(6'd10, "R4 word unchanged");

    // R8 standby with toggling strobe
    go_standby(6'd3, 1'b0);
    go_standby(6'd10, 1'b1);
    go_standby(6'd3, 1'b0);
    go_standby(6'd3, 1'b1);
    do_read(6'd10, "R8 contents retained");

    // R2 strobe falls in standby, select arrives with strobe low
    go_standby(6'd10, 1'b0);
    @(negedge clk);
    chip_sel_n = 0; wr_strobe_n = 0; addr = 6'd10; wr_data = 16'hDEAD;
    bit_mask_n = '0;
    expect_out("R2 no start, hold", exp_last);
    do_read(6'd10, "R2 no write without start edge");

    // R5 select drops before strobe rises: aborted
    @(negedge clk);
    chip_sel_n = 0; wr_strobe_n = 0; addr = 6'd3; wr_data = 16'h0F0F;
    bit_mask_n = '0;
    expect_out("R9 hold abort start", exp_last);
    go_standby(6'd3, 1'b0);
    go_standby(6'd3, 1'b1);
    do_read(6'd3, "R5 aborted write discarded");

    // R10 output enable independent of data
    @(negedge clk); out_en_n = 1;
    do_read(6'd10, "R10 drive off");
    do_read(6'd3, "R10 drive off, data register moves");
    @(negedge clk); out_en_n = 0;
    expect_out("R10 drive back on, latest data", exp_last);

    // Mixed pattern sweep
    for (int i = 0; i < 8; i++) begin
      do_write(AW'(20 + i), WIDTH'(16'h3C5A ^ (i * 16'h1111)), '0,
               "R4 sweep full write");
    end
    for (int i = 0; i < 8; i++) begin
      do_write(AW'(20 + i), WIDTH'(~(i * 16'h0123)),
               WIDTH'(16'hAAAA >> i), "R3 sweep masked write");
    end
    for (int i = 7; i >= 0; i--) begin
      do_read(AW'(20 + i), "R6 sweep readback");
    end

    repeat (4) @(negedge clk);
    if (q_due.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d pending, expected 0", q_due.size());
    end
    summary();
  end
endmodule